// File: doc/BRIEF.md
# Dual-Channel Buffered Pulse-Width Modulator

This block produces two pulse-width modulated outputs, an even channel and an odd channel. Both share one free-running 8-bit up counter, so both run at the same frequency. Each time the counter passes its all-ones value it restarts from a programmable start value held in a period register. A larger start value therefore gives a shorter period of 256 minus the start value clocks. At that restart both outputs go high. Each one then drops low when the counter reaches that channel's duty value.

Software programs the block through a small write port with three registers: one duty register per channel and the period register. The live counter value is always visible on a read-only output. Duty values pass through a shadow buffer that is loaded only at the restart. A write made at any point in a period therefore never disturbs the waveform already in progress; it takes effect from the next period.

Top module: `pwm_pair`

## Requirements
- R1: While reset is active, and right after it, the counter, the period register and both shadow buffers are zero and both outputs are low. The first full period after reset therefore has both outputs low for all 256 clocks.
- R2: Outside a restart, the counter rises by exactly one on every clock, and `count_o` shows its current value.
- R3: On the clock after the counter holds all-ones, the counter loads the period register value P. Every period then lasts 256 − P clocks.
- R4: At the restart, each shadow buffer copies its channel's duty register. Each output goes high at that restart, unless the rules for a duty of zero or a duty equal to P hold it low. An output only ever rises at a restart.
- R5: For a buffered duty D with D ≥ P and D ≠ 0, the output is high for exactly D − P clocks per period. It is low from the clock in which the counter equals D.
- R6: A duty write made in the middle of a period leaves that period's waveform unchanged. The new value shapes the next period.
- R7: A buffered duty of 0 keeps the output low for the whole period. This force-low takes priority over the set at the restart.
- R8: With P = 0 and D = 255, the output is high for 255 of every 256 clocks.
- R9: A non-zero buffered duty D below P never matches the counter, so the output stays high for all 256 − P clocks of the period.
- R10: A write with `wr_sel` 0 sets the even duty, 1 sets the odd duty, and 2 sets the period. A write with `wr_sel` 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one write per clock |
| wr_sel | input | 2 | Register select: 0 even duty, 1 odd duty, 2 period, 3 unused |
| wr_data | input | CW (8) | Write data |
| count_o | output | CW (8) | Live counter value |
| pwm_even_o | output | 1 | Even channel PWM output |
| pwm_odd_o | output | 1 | Odd channel PWM output |

## Verification
The assertions check every cycle the properties that hold one clock at a time. These are the single-step count, the reload from the period register after all-ones, and rising outputs appearing only right after all-ones. They also cover the shadow buffers holding steady between restarts, a zero duty forcing the output low, and a falling output coinciding with a counter match. The high-time and period counts over whole periods cannot be seen from a single clock, so only the bench scenarios show them. The same applies to the deferred effect of a mid-period duty write and to a write on the unused select having no effect.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    // Number of output channels in one module (even + odd)
    localparam int unsigned NUM_CH = 2;
    // Width of the register select field
    localparam int unsigned SEL_W  = 2;

    // Register select codes on the write port
    typedef enum logic [SEL_W-1:0] {
        SEL_DUTY_EVEN = 2'd0,
        SEL_DUTY_ODD  = 2'd1,
        SEL_PERIOD    = 2'd2,
        SEL_UNUSED    = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/pwm_regs.sv
// Software-visible duty and period registers.
module pwm_regs
    import pwm_pair_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [CW-1:0]                wr_data,
    output logic [NUM_CH-1:0][CW-1:0]    duty_o,
    output logic [CW-1:0]                period_o
);

    typedef struct packed {
        logic [NUM_CH-1:0][CW-1:0] duty;
        logic [CW-1:0]             period;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (reg_sel_e'(wr_sel))
                SEL_DUTY_EVEN: regs_d.duty[0] = wr_data;
                SEL_DUTY_ODD:  regs_d.duty[1] = wr_data;
                SEL_PERIOD:    regs_d.period  = wr_data;
                default:       regs_d         = regs_q;  // unused select: no effect
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign duty_o   = regs_q.duty;
    assign period_o = regs_q.period;

endmodule

// File: rtl/pwm_timebase.sv
// Shared up counter, reloaded from the period register after all-ones.
module pwm_timebase #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] period_i,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_nxt_o,
    output logic          wrap_o
);

    localparam logic [CW-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      wrap;

    always_comb begin
        wrap = (st_q.cnt == CNT_TOP);
        st_d = st_q;
        if (wrap) begin
            st_d.cnt = period_i;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o     = st_q.cnt;
    assign cnt_nxt_o = st_d.cnt;
    assign wrap_o    = wrap;

endmodule

// File: rtl/pwm_channel.sv
// One output channel: shadow buffer, comparator and set/clear output latch.
module pwm_channel #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wrap_i,
    input  logic [CW-1:0] cnt_nxt_i,
    input  logic [CW-1:0] duty_i,
    output logic [CW-1:0] dbuf_o,
    output logic          pwm_o
);

    typedef struct packed {
        logic [CW-1:0] dbuf;
        logic          out;
    } ch_state_t;

    ch_state_t ch_d, ch_q;
    logic      set_ok;
    logic      hit;

    always_comb begin
        ch_d = ch_q;
        // At restart: a zero duty, or a duty equal to the reload value,
        // clears in the same clock, so clear wins over set.
        set_ok = (duty_i != '0) && (cnt_nxt_i != duty_i);
        // Mid period: drop the output as the counter arrives at the buffer.
        hit    = (cnt_nxt_i == ch_q.dbuf);
        if (wrap_i) begin
            ch_d.dbuf = duty_i;
            ch_d.out  = set_ok;
        end else if (hit) begin
            ch_d.out  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q <= '0;
        end else begin
            ch_q <= ch_d;
        end
    end

    assign dbuf_o = ch_q.dbuf;
    assign pwm_o  = ch_q.out;

endmodule

// File: rtl/pwm_pair.sv
// Two-channel PWM module sharing one counter and one period register.
module pwm_pair
    import pwm_pair_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [CW-1:0]    wr_data,
    output logic [CW-1:0]    count_o,
    output logic             pwm_even_o,
    output logic             pwm_odd_o
);

    logic [NUM_CH-1:0][CW-1:0] duty_w;
    logic [NUM_CH-1:0][CW-1:0] dbuf_w;
    logic [NUM_CH-1:0]         pwm_w;
    logic [CW-1:0]             period_w;
    logic [CW-1:0]             cnt_w;
    logic [CW-1:0]             cnt_nxt_w;
    logic                      wrap_w;

    pwm_regs #(.CW(CW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .duty_o   (duty_w),
        .period_o (period_w)
    );

    pwm_timebase #(.CW(CW)) u_tbase (
        .clk       (clk),
        .rst_n     (rst_n),
        .period_i  (period_w),
        .cnt_o     (cnt_w),
        .cnt_nxt_o (cnt_nxt_w),
        .wrap_o    (wrap_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_channel #(.CW(CW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wrap_i    (wrap_w),
            .cnt_nxt_i (cnt_nxt_w),
            .duty_i    (duty_w[g]),
            .dbuf_o    (dbuf_w[g]),
            .pwm_o     (pwm_w[g])
        );
    end

    assign count_o    = cnt_w;
    assign pwm_even_o = pwm_w[0];
    assign pwm_odd_o  = pwm_w[1];

endmodule

// File: rtl/pwm_pair_chk.sv
// Cycle-level checks for pwm_pair, attached by bind.
module pwm_pair_chk
    import pwm_pair_pkg::*;
#(
    parameter int unsigned CW = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [CW-1:0]             count,
    input logic [CW-1:0]             period,
    input logic [NUM_CH-1:0][CW-1:0] duty,
    input logic [NUM_CH-1:0][CW-1:0] dbufv,
    input logic [NUM_CH-1:0]         pwm
);

    localparam logic [CW-1:0] TOP = '1;

    // R2: single-step count away from the top
    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (count != TOP) |=> (count == CW'($past(count) + 1'b1)));

    // R3: reload from the period register after all-ones
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP) |=> (count == $past(period)));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R4: an output rises only right after the counter held all-ones
        p_rise_at_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwm[i]) |-> ($past(count) == TOP));

        // R6: buffer is frozen between restarts
        p_buf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (count != TOP) |=> $stable(dbufv[i]));

        // R7: zero duty at restart keeps the output low
        p_zero_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ((count == TOP) && (duty[i] == '0)) |=> !pwm[i]);

        // R5: a fall coincides with a match (or a zero buffer)
        p_fall_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pwm[i]) |-> ((count == dbufv[i]) || (dbufv[i] == '0)));
    end

endmodule

bind pwm_pair pwm_pair_chk #(.CW(CW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .count  (count_o),
    .period (period_w),
    .duty   (duty_w),
    .dbufv  (dbuf_w),
    .pwm    (pwm_w)
);

// File: tb/sim_pwm_pair.sv
`timescale 1ns/1ps
module sim_pwm_pair;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] count_o;
    logic       pwm_even_o;
    logic       pwm_odd_o;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;  // 50 MHz

    pwm_pair u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .count_o    (count_o),
        .pwm_even_o (pwm_even_o),
        .pwm_odd_o  (pwm_odd_o)
    );

    typedef struct {
        string tag;
        int    len;
        int    hi0;
        int    hi1;
    } exp_t;

    exp_t q[$];
    event bnd;

    task automatic chk(string tag, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int exp_hi(int p, int d);
        if (d == 0) return 0;
        if (d >= p) return d - p;
        return 256 - p;
    endfunction

    function automatic exp_t mk(string tag, int p, int d0, int d1);
        exp_t e;
        e.tag = tag;
        e.len = 256 - p;
        e.hi0 = exp_hi(p, d0);
        e.hi1 = exp_hi(p, d1);
        return e;
    endfunction

    // Monitor: measure each whole period and compare with the scoreboard
    int         len_acc = 0;
    int         hi0_acc = 0;
    int         hi1_acc = 0;
    logic [7:0] prev = 8'd0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev == 8'hFF) begin
                if (q.size() > 0) begin
                    exp_t e;
                    e = q.pop_front();
                    chk({e.tag, " period"}, len_acc, e.len);
                    chk({e.tag, " even high"}, hi0_acc, e.hi0);
                    chk({e.tag, " odd high"}, hi1_acc, e.hi1);
                end
                len_acc = 0;
                hi0_acc = 0;
                hi1_acc = 0;
                -> bnd;
            end
            len_acc++;
            hi0_acc += int'(pwm_even_o);
            hi1_acc += int'(pwm_odd_o);
            prev = count_o;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    // Driver: program during one period, expect the values in the next
    task automatic run_cfg(string tag, int p, int d0, int d1);
        @(bnd);
        wr(2'd2, 8'(p));
        wr(2'd0, 8'(d0));
        wr(2'd1, 8'(d1));
        @(bnd);
        q.push_back(mk(tag, p, d0, d1));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 count in reset", int'(count_o), 0);
        chk("R1 even in reset", int'(pwm_even_o), 0);
        chk("R1 odd in reset", int'(pwm_odd_o), 0);
        // R1: first period after reset is fully low on both outputs
        q.push_back(mk("R1", 0, 0, 0));
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R2: counter steps by one
        @(negedge clk);
        chk("R2 count start", int'(count_o), 0);
        @(negedge clk);
        chk("R2 count step", int'(count_o), 1);
        @(negedge clk);
        chk("R2 count step", int'(count_o), 2);

        // R3/R5: half and quarter duty on a full-length period
        run_cfg("R5", 8'h00, 8'h80, 8'h40);
        // R8 (near-full) and R7 (zero) together
        run_cfg("R8_R7", 8'h00, 8'hFF, 8'h00);
        // R3 shortened period, R9 duty below period stays high
        run_cfg("R3_R9", 8'h40, 8'h90, 8'h20);
        // R5 duty equal to reload gives zero high time; one above gives one
        run_cfg("R5_edge", 8'h40, 8'h40, 8'h41);
        // R7 zero duty with a non-zero period
        run_cfg("R7", 8'hC0, 8'h00, 8'hF0);

        // R6: mid-period duty write takes effect only next period
        run_cfg("R6_before", 8'h80, 8'hC0, 8'h10);
        repeat (20) @(negedge clk);
        wr(2'd0, 8'hA0);
        wr(2'd1, 8'h90);
        @(bnd);
        q.push_back(mk("R6_after", 8'h80, 8'hA0, 8'h90));

        // R10: writes land on the selected register; select 3 does nothing
        run_cfg("R10_map", 8'h20, 8'h60, 8'hE0);
        wr(2'd3, 8'h00);
        wr(2'd3, 8'hF8);
        @(bnd);
        q.push_back(mk("R10_unused", 8'h20, 8'h60, 8'hE0));

        // Drain the scoreboard
        @(bnd);
        chk("scoreboard drained", q.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule